// File: doc/BRIEF.md
# Hibernate Entry and Wake Sequencer

This block takes a processor system from full-speed operation into a deep power-down state and back again. When the core pipeline reports that a hibernate instruction has retired, the sequencer asks the DRAM controller for self-refresh. Once self-refresh is acknowledged it waits for the internal system bus to go idle. It then forces every gated clock to a constant high level and turns off the PLL. Only after that does it drop the main power enable. The real-time clock and the wake-source monitor are not gated and keep running throughout.

While powered down, the sequencer watches a vector of wake interrupt requests, each qualified by its own enable bit. An enabled request starts the power-up sequence: power returns, the PLL restarts and lock is awaited, clocks are released, and finally a one-cycle restart request is issued to the core together with the cold reset address 0xBFC00000. A wake that arrives while entry is still waiting on a handshake cancels the entry instead. In that case self-refresh is withdrawn and the system goes back to full speed without a restart. Every handshake wait is bounded, and a wait that runs out moves the block to a sticky error state.

The PLL, DRAM controller and real-time clock sit outside the block and are seen only as handshake pins. All control and status pins are plain levels; no pin carries a data stream, so there is no valid/ready back-pressure at the edge.

Top module: `hib_seq`

## Requirements
- R1: While reset is asserted and right after it, `state` is 0 (run), `pwr_en`=1, `pll_en`=1, `clk_hold`=0, `sr_req`=0, `restart_req`=0, `err`=0, `restart_addr`=0.
- R2: In run (state 0), a sampled `hib_req`=1 moves the block to state 1, which raises `sr_req` and waits for `sr_ack`.
- R3: After `sr_ack` is sampled in state 1, the block enters state 2 and does not stop clocks until `bus_idle` is sampled high.
- R4: Clock stop is state 3, lasting exactly one cycle with `clk_hold`=1 (gated clocks forced high), `pll_en`=0 and `pwr_en` still 1. State 4 (off) follows with `pwr_en`=0, `clk_hold`=1, `pll_en`=0 and `sr_req`=1.
- R5: In state 4 a wake is any bit set in both `wake_irq` and `wake_en`. Requests whose enable bit is 0 are ignored. A wake during the one-cycle state 3 has no effect there.
- R6: Wake order: state 5 (one cycle, `pwr_en`=1, `pll_en`=0); state 6 (`pll_en`=1) until `pll_lock`; state 7 (one cycle, `clk_hold`=0); state 8 (one cycle, `restart_req`=1, `restart_addr`=0xBFC00000, `sr_req`=0); then run.
- R7: An enabled wake sampled in state 1 or 2 moves to state 9 (abort) with `sr_req`=0 and clocks and power untouched. The block returns to run once `sr_ack` is sampled low, and `restart_req` is never pulsed.
- R8: Staying in a waiting state (1, 2, 6 or 9) for TMO_CYC cycles without its exit condition moves the block to state 10. State 10 drives `err`=1, `pwr_en`=1, `pll_en`=1, `clk_hold`=0 and `sr_req`=0, and is left only by reset.
- R9: In states 1 and 2 a wake takes priority over `sr_ack`/`bus_idle`. An exit condition present on the last allowed cycle of a wait takes priority over the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hib_req | input | 1 | Hibernate instruction retired past write-back |
| sr_ack | input | 1 | DRAM is in self-refresh |
| bus_idle | input | 1 | Internal system bus idle |
| pll_lock | input | 1 | PLL locked |
| wake_irq | input | N_WAKE | Wake interrupt requests |
| wake_en | input | N_WAKE | Per-request wake enables |
| sr_req | output | 1 | Self-refresh request to DRAM controller |
| clk_hold | output | 1 | Force gated clocks to constant high |
| pll_en | output | 1 | PLL enable |
| pwr_en | output | 1 | Main power enable |
| restart_req | output | 1 | One-cycle cold restart request to the core |
| restart_addr | output | 32 | Restart address, valid with restart_req |
| err | output | 1 | Sticky handshake timeout |
| state | output | 4 | Sequencer state code |

## Verification
The bench targets a wake that is present during entry: in state 1 together with `sr_ack`, and in state 2 with `sr_ack` still high. A design that ignored the abort would cut power with a wake already pending. A design that skipped the `sr_ack` drop would return to run while DRAM is still in self-refresh. It also drives only disabled wake bits during power-down, which a missing mask would turn into a spurious wake. It presents an acknowledge on exactly the last cycle before a timeout, where an off-by-one counter would either fall into the error state or wait one cycle too long. Timeouts in the self-refresh and PLL waits must latch the error, and later hibernate requests must not leave it.

// File: rtl/hib_pkg.sv
package hib_pkg;

  typedef enum logic [3:0] {
    ST_RUN   = 4'd0,
    ST_SRQ   = 4'd1,
    ST_BUSW  = 4'd2,
    ST_CSTOP = 4'd3,
    ST_OFF   = 4'd4,
    ST_PUP   = 4'd5,
    ST_PLLW  = 4'd6,
    ST_CON   = 4'd7,
    ST_RST   = 4'd8,
    ST_ABORT = 4'd9,
    ST_ERR   = 4'd10
  } hib_st_e;

  typedef struct packed {
    logic sr;
    logic hold;
    logic pll;
    logic pwr;
    logic rst;
    logic err;
  } hib_out_s;

endpackage

// File: rtl/hib_wake_mask.sv
module hib_wake_mask #(
  parameter int N_WAKE = 4
) (
  input  logic [N_WAKE-1:0] irq,
  input  logic [N_WAKE-1:0] en,
  output logic              hit
);
  logic [N_WAKE-1:0] qual;

  for (genvar g = 0; g < N_WAKE; g++) begin : g_bit
    assign qual[g] = irq[g] & en[g];
  end

  assign hit = |qual;
endmodule

// File: rtl/hib_tmo.sv
module hib_tmo #(
  parameter int TMO_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] cnt_q;

  assign expired = (cnt_q == CW'(TMO_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear)          cnt_q <= '0;
    else if (run && !expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/hib_out_dec.sv
module hib_out_dec
  import hib_pkg::*;
(
  input  hib_st_e  st,
  output hib_out_s o
);
  always_comb begin
    o = '{sr: 1'b0, hold: 1'b0, pll: 1'b1, pwr: 1'b1, rst: 1'b0, err: 1'b0};
    unique case (st)
      ST_SRQ, ST_BUSW: o.sr = 1'b1;
      ST_CSTOP: begin o.sr = 1'b1; o.hold = 1'b1; o.pll = 1'b0; end
      ST_OFF:   begin o.sr = 1'b1; o.hold = 1'b1; o.pll = 1'b0; o.pwr = 1'b0; end
      ST_PUP:   begin o.sr = 1'b1; o.hold = 1'b1; o.pll = 1'b0; end
      ST_PLLW:  begin o.sr = 1'b1; o.hold = 1'b1; end
      ST_CON:   o.sr = 1'b1;
      ST_RST:   o.rst = 1'b1;
      ST_ERR:   o.err = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/hib_seq.sv
module hib_seq
  import hib_pkg::*;
#(
  parameter int          N_WAKE      = 4,
  parameter int          TMO_CYC     = 16,
  parameter logic [31:0] RESTART_VEC = 32'hBFC0_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hib_req,
  input  logic              sr_ack,
  input  logic              bus_idle,
  input  logic              pll_lock,
  input  logic [N_WAKE-1:0] wake_irq,
  input  logic [N_WAKE-1:0] wake_en,
  output logic              sr_req,
  output logic              clk_hold,
  output logic              pll_en,
  output logic              pwr_en,
  output logic              restart_req,
  output logic [31:0]       restart_addr,
  output logic              err,
  output logic [3:0]        state
);
  hib_st_e  st_q, st_d;
  hib_out_s dec;
  logic     wake, expired, waiting;

  hib_wake_mask #(.N_WAKE(N_WAKE)) u_mask (
    .irq(wake_irq), .en(wake_en), .hit(wake)
  );

  assign waiting = (st_q == ST_SRQ) || (st_q == ST_BUSW) ||
                   (st_q == ST_PLLW) || (st_q == ST_ABORT);

  hib_tmo #(.TMO_CYC(TMO_CYC)) u_tmo (
    .clk(clk), .rst_n(rst_n), .clear(st_d != st_q), .run(waiting),
    .expired(expired)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_RUN:   if (hib_req) st_d = ST_SRQ;
      ST_SRQ: begin
        if (wake)         st_d = ST_ABORT;
        else if (sr_ack)  st_d = ST_BUSW;
        else if (expired) st_d = ST_ERR;
      end
      ST_BUSW: begin
        if (wake)          st_d = ST_ABORT;
        else if (bus_idle) st_d = ST_CSTOP;
        else if (expired)  st_d = ST_ERR;
      end
      ST_CSTOP: st_d = ST_OFF;
      ST_OFF:   if (wake) st_d = ST_PUP;
      ST_PUP:   st_d = ST_PLLW;
      ST_PLLW: begin
        if (pll_lock)     st_d = ST_CON;
        else if (expired) st_d = ST_ERR;
      end
      ST_CON:   st_d = ST_RST;
      ST_RST:   st_d = ST_RUN;
      ST_ABORT: begin
        if (!sr_ack)      st_d = ST_RUN;
        else if (expired) st_d = ST_ERR;
      end
      ST_ERR:   st_d = ST_ERR;
      default:  st_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_RUN;
    else        st_q <= st_d;
  end

  hib_out_dec u_dec (.st(st_q), .o(dec));

  assign sr_req       = dec.sr;
  assign clk_hold     = dec.hold;
  assign pll_en       = dec.pll;
  assign pwr_en       = dec.pwr;
  assign restart_req  = dec.rst;
  assign err          = dec.err;
  assign restart_addr = dec.rst ? RESTART_VEC : 32'd0;
  assign state        = st_q;
endmodule

// File: rtl/hib_seq_chk.sv
module hib_seq_chk #(
  parameter logic [31:0] RESTART_VEC = 32'hBFC0_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_idle,
  input logic        pll_lock,
  input logic        sr_req,
  input logic        clk_hold,
  input logic        pll_en,
  input logic        pwr_en,
  input logic        restart_req,
  input logic [31:0] restart_addr,
  input logic        err,
  input logic [3:0]  state
);
  AST_OFF_CLOCKS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> (clk_hold && !pll_en && sr_req)); // R4

  AST_POWER_AFTER_CLKSTOP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> ($past(clk_hold) && !$past(pll_en))); // R4

  AST_CLKSTOP_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_hold) |-> ($past(bus_idle) && sr_req)); // R3

  AST_UNGATE_AFTER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(clk_hold) && !err) |-> ($past(pll_lock) && pwr_en && pll_en)); // R6

  AST_RESTART_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |=> !restart_req); // R6

  AST_RESTART_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    restart_req |-> (restart_addr == RESTART_VEC)); // R6

  AST_ABORT_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 4'd9) |=> !restart_req); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err); // R8
endmodule

bind hib_seq hib_seq_chk #(.RESTART_VEC(RESTART_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .pll_lock(pll_lock),
  .sr_req(sr_req), .clk_hold(clk_hold), .pll_en(pll_en), .pwr_en(pwr_en),
  .restart_req(restart_req), .restart_addr(restart_addr), .err(err),
  .state(state)
);

// File: tb/test_hib_seq.sv
module test_hib_seq;
  localparam int NW  = 4;
  localparam int TMO = 16;
  localparam logic [31:0] VEC = 32'hBFC0_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hib_req = 0, sr_ack = 0, bus_idle = 0, pll_lock = 0;
  logic [NW-1:0] wake_irq = '0, wake_en = '0;
  logic sr_req, clk_hold, pll_en, pwr_en, restart_req, err;
  logic [31:0] restart_addr;
  logic [3:0] state;

  int checks = 0, errors = 0, restarts = 0;

  always #10 clk = ~clk;

  hib_seq #(.N_WAKE(NW), .TMO_CYC(TMO), .RESTART_VEC(VEC)) i_hib_seq (
    .clk(clk), .rst_n(rst_n), .hib_req(hib_req), .sr_ack(sr_ack),
    .bus_idle(bus_idle), .pll_lock(pll_lock), .wake_irq(wake_irq),
    .wake_en(wake_en), .sr_req(sr_req), .clk_hold(clk_hold),
    .pll_en(pll_en), .pwr_en(pwr_en), .restart_req(restart_req),
    .restart_addr(restart_addr), .err(err), .state(state)
  );

  // Behavioural reference: state number and cycles spent waiting
  int m_st = 0, m_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st  <= 0;
      m_cnt <= 0;
    end else begin
      int  nx;
      bit  wk, late;
      wk   = ((wake_irq & wake_en) != 0);
      late = (m_cnt == TMO - 1);
      nx   = m_st;
      case (m_st)
        0:  if (hib_req) nx = 1;
        1:  nx = wk ? 9 : sr_ack ? 2 : late ? 10 : 1;
        2:  nx = wk ? 9 : bus_idle ? 3 : late ? 10 : 2;
        3:  nx = 4;
        4:  if (wk) nx = 5;
        5:  nx = 6;
        6:  nx = pll_lock ? 7 : late ? 10 : 6;
        7:  nx = 8;
        8:  nx = 0;
        9:  nx = !sr_ack ? 0 : late ? 10 : 9;
        default: nx = 10;
      endcase
      if (nx != m_st) m_cnt <= 0;
      else if (m_st inside {1, 2, 6, 9} && !late) m_cnt <= m_cnt + 1;
      m_st <= nx;
    end
  end

  function automatic string req_of(int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      9: return "R7";
      10: return "R8";
      default: return "R6";
    endcase
  endfunction

  // Expected {sr,hold,pll,pwr,rst,err} per state, from the requirements
  function automatic logic [5:0] exp_out(int s);
    case (s)
      1, 2: return 6'b101100;
      3:    return 6'b110100;
      4:    return 6'b110000;
      5:    return 6'b110100;
      6:    return 6'b111100;
      7:    return 6'b101100;
      8:    return 6'b001110;
      10:   return 6'b001101;
      default: return 6'b001100;
    endcase
  endfunction

  always @(negedge clk) begin
    logic [5:0] act, ex;
    logic [31:0] ea;
    act = {sr_req, clk_hold, pll_en, pwr_en, restart_req, err};
    ex  = exp_out(m_st);
    ea  = (m_st == 8) ? VEC : 32'd0;
    if (restart_req) restarts++;
    checks++;
    if (state !== 4'(m_st) || act !== ex || restart_addr !== ea) begin
      errors++;
      $display("FAIL %s state=%0d outs=%b addr=%h expected state=%0d outs=%b addr=%h",
               req_of(m_st), state, act, restart_addr, m_st, ex, ea);
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int ex);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, ex);
    end
  endtask

  task automatic wait_state(input int s, input string rq);
    int n = 0;
    while (state != 4'(s) && n < 200) begin
      @(negedge clk);
      n++;
    end
    check(state == 4'(s), rq, "reach state", int'(state), s);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    hib_req = 0; sr_ack = 0; bus_idle = 0; pll_lock = 0; wake_irq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic hib_go();
    hib_req = 1'b1;
    @(negedge clk);
    hib_req = 1'b0;
  endtask

  task automatic run_all();
    int r0;
    // R1 reset values
    wake_en = 4'b0011;
    repeat (2) @(negedge clk);
    check(state == 0 && pwr_en && pll_en && !clk_hold && !sr_req && !err,
          "R1", "reset outputs", int'(state), 0);
    do_reset();
    check(state == 0 && pwr_en && !restart_req, "R1", "after reset", int'(state), 0);

    // Full hibernate and cold wake
    r0 = restarts;
    hib_go();
    check(state == 1 && sr_req, "R2", "self-refresh request", int'(state), 1);
    repeat (3) @(negedge clk);
    sr_ack = 1'b1;
    wait_state(2, "R3");
    repeat (4) @(negedge clk);
    check(state == 2 && !clk_hold, "R3", "hold for bus idle", int'(state), 2);
    bus_idle = 1'b1;
    wait_state(3, "R4");
    check(clk_hold && !pll_en && pwr_en, "R4", "clock stop outputs", int'(pwr_en), 1);
    @(negedge clk);
    check(state == 4 && !pwr_en, "R4", "power removed", int'(pwr_en), 0);
    bus_idle = 1'b0;
    wake_irq = 4'b1100;
    repeat (5) @(negedge clk);
    check(state == 4, "R5", "masked wake ignored", int'(state), 4);
    wake_irq = 4'b0101;
    wait_state(5, "R5");
    wake_irq = '0;
    check(pwr_en && !pll_en, "R6", "power before PLL", int'(pll_en), 0);
    wait_state(6, "R6");
    repeat (3) @(negedge clk);
    pll_lock = 1'b1;
    wait_state(7, "R6");
    check(!clk_hold, "R6", "clocks released", int'(clk_hold), 0);
    @(negedge clk);
    check(restart_req && restart_addr == VEC, "R6", "restart vector",
          int'(restart_addr[15:0]), int'(VEC[15:0]));
    sr_ack = 1'b0; pll_lock = 1'b0;
    @(negedge clk);
    check(state == 0 && restarts == r0 + 1, "R6", "single restart pulse", restarts - r0, 1);

    // Abort in state 1: wake together with ack
    r0 = restarts;
    hib_go();
    sr_ack = 1'b1; wake_irq = 4'b0010;
    @(negedge clk);
    check(state == 9 && !sr_req, "R9", "wake beats ack", int'(state), 9);
    wake_irq = '0;
    repeat (2) @(negedge clk);
    sr_ack = 1'b0;
    wait_state(0, "R7");
    check(restarts == r0 && pwr_en && !clk_hold, "R7", "abort without restart", restarts - r0, 0);

    // Abort in state 2
    hib_go();
    sr_ack = 1'b1;
    wait_state(2, "R3");
    wake_irq = 4'b0001; bus_idle = 1'b1;
    @(negedge clk);
    check(state == 9, "R9", "wake beats bus idle", int'(state), 9);
    wake_irq = '0; bus_idle = 1'b0;
    @(negedge clk);
    sr_ack = 1'b0;
    wait_state(0, "R7");

    // Ack on the last allowed cycle beats timeout
    hib_req = 1'b1;
    @(negedge clk);
    hib_req = 1'b0;
    repeat (TMO - 1) @(negedge clk);
    check(state == 1, "R9", "still waiting", int'(state), 1);
    sr_ack = 1'b1;
    @(negedge clk);
    check(state == 2 && !err, "R9", "ack at deadline", int'(state), 2);
    wake_irq = 4'b0001;
    @(negedge clk);
    wake_irq = '0; sr_ack = 1'b0;
    wait_state(0, "R7");

    // Timeout waiting for self-refresh
    hib_go();
    repeat (TMO + 2) @(negedge clk);
    check(state == 10 && err && !sr_req && pwr_en, "R8", "self-refresh timeout", int'(state), 10);
    hib_go();
    sr_ack = 1'b1; wake_irq = 4'b0001;
    repeat (3) @(negedge clk);
    check(err, "R8", "error sticky", int'(err), 1);
    do_reset();
    check(state == 0 && !err, "R1", "reset clears error", int'(state), 0);

    // Timeout waiting for PLL lock
    hib_go();
    sr_ack = 1'b1; bus_idle = 1'b1;
    wait_state(4, "R4");
    bus_idle = 1'b0; wake_irq = 4'b0010;
    wait_state(6, "R6");
    wake_irq = '0;
    repeat (TMO + 2) @(negedge clk);
    check(state == 10 && err && !clk_hold && pll_en, "R8", "PLL timeout", int'(state), 10);
    do_reset();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule